// File: doc/BRIEF.md
# Scan and Fold Unit with Looped and Unrolled Forms

This block applies one associative binary operator across a vector of N operands and produces two results: the running prefix values (the scan) and the final combined value (the fold). The operator is add, multiply, maximum or XOR. One operator cell serves as the loop body. It takes the stored state as its left operand and the new operand as its right operand, and its result becomes both the next state and the scan element.

The block has two forms that share this body. The unrolled form chains N copies of the cell. It takes an initial value and the whole operand vector on one bus and returns the complete scan vector and the fold without a clock. The looped form keeps one cell and a state register. A start pulse seeds the register with the initial value. After that it takes one operand on each cycle in which the input valid is high, shows each new state as a scan element, and marks the fold when the N-th operand has been taken. Given the same operator, initial value and operands, the scan sequence from the looped form equals the scan vector from the unrolled form, element by element. Its final state equals the unrolled fold.

Top module: `scan_fold_unit`

## Requirements
- R1: After reset, scan_valid and fold_valid are low and both scan_out and fold_out are zero.
- R2: op_sel encodes the operator: 0 is addition modulo 2^W, 1 is multiplication keeping the low W bits, 2 is unsigned maximum, and 3 is bitwise XOR.
- R3: A start pulse loads init_val into the state, so scan_out shows init_val on the following cycle. Every update computes op(state, operand) with the state on the left. op_sel must stay unchanged from start until the fold.
- R4: An operand is accepted when in_valid is high, a run is active and start is low. On the next cycle, scan_out holds the new state and scan_valid is high for one cycle.
- R5: While in_valid is low, the state and scan_out hold and scan_valid stays low.
- R6: On the cycle after the N-th operand is accepted, fold_valid is high for exactly one cycle together with scan_valid. fold_out then equals that last scan element and keeps this value until the next fold completes.
- R7: Operands offered before any start, or after the N-th operand of a run, are ignored: scan_out, scan_valid and fold_out do not change.
- R8: When start and in_valid are high in the same cycle, start wins and that operand is discarded, so the state equals init_val afterwards.
- R9: In the unrolled form, comb_scan bits [k*W +: W] equal init_val combined in order with vec_in elements 0..k, where element j sits at bits [j*W +: W]. comb_fold equals element N-1. Both follow their inputs with no clock.
- R10: For the same operator, initial value and operands, the k-th looped scan element equals comb_scan element k, and the looped fold equals comb_fold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 2 | Operator select: 0 add, 1 multiply, 2 max, 3 XOR |
| init_val | input | W | Seed value for both forms |
| start | input | 1 | Pulse that begins a looped run and loads init_val |
| in_valid | input | 1 | Looped-form operand valid |
| in_data | input | W | Looped-form operand |
| scan_out | output | W | Current looped state (latest scan element) |
| scan_valid | output | 1 | scan_out holds a freshly produced element |
| fold_out | output | W | Fold result of the last completed run |
| fold_valid | output | 1 | One-cycle pulse when a run has folded N operands |
| vec_in | input | N*W | Unrolled-form operand vector, element j at bits [j*W +: W] |
| comb_scan | output | N*W | Unrolled scan vector, element k at bits [k*W +: W] |
| comb_fold | output | W | Unrolled fold result |

## Verification
On every cycle, the assertions check these properties of the looped form: the state holds when no operand is offered, fold_valid lasts one cycle and never appears without scan_valid, scan_valid only follows a cycle with in_valid high, the operand count never passes N, and op_sel stays fixed while a run is active. Only the bench scenarios can show that the operator values are correct, including wrap-around, truncation and unsigned compare. The same is true of the left-first operand order, the rejection of operands before a start or after a fold, and the priority of start over an operand in the same cycle. The bench also shows that the looped scan sequence equals the unrolled scan vector over random operands with random idle gaps.

// File: rtl/scan_fold_pkg.sv
// Package: operator codes shared by the scan/fold unit and its bench.
// Assumes the 2-bit encoding is decoded identically by every operator cell.
package scan_fold_pkg;
    typedef enum logic [1:0] {
        SF_ADD = 2'd0,
        SF_MUL = 2'd1,
        SF_MAX = 2'd2,
        SF_XOR = 2'd3
    } sf_op_e;
endpackage

// File: rtl/sf_op_cell.sv
// Module: sf_op_cell
// One copy of the loop body. It combines the left operand (the state) with the
// right operand (the new element) under the selected operator.
// Assumes unsigned operands; multiply and add wrap to W bits.
module sf_op_cell
    import scan_fold_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);
    sf_op_e op;

    // Decode the operator code and compute the result.
    always_comb begin
        op = sf_op_e'(op_sel);
        case (op)
            SF_ADD:  res = W'(lhs + rhs);
            SF_MUL:  res = W'(lhs * rhs);
            SF_MAX:  res = (lhs >= rhs) ? lhs : rhs;
            default: res = lhs ^ rhs;
        endcase
    end
endmodule

// File: rtl/sf_comb_chain.sv
// Module: sf_comb_chain
// Unrolled form: N operator cells in a row. Cell k combines the running value
// from cell k-1 (init for k = 0) with vector element k.
// Assumes element j of vec_in sits at bits [j*W +: W].
module sf_comb_chain #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic [1:0]     op_sel,
    input  logic [W-1:0]   init_val,
    input  logic [N*W-1:0] vec_in,
    output logic [N*W-1:0] scan_vec,
    output logic [W-1:0]   fold_val
);
    logic [W-1:0] stage [0:N];

    // Seed the chain with the initial value.
    always_comb stage[0] = init_val;

    for (genvar k = 0; k < N; k++) begin : g_cell
        sf_op_cell #(.W(W)) i_cell (
            .op_sel (op_sel),
            .lhs    (stage[k]),
            .rhs    (vec_in[k*W +: W]),
            .res    (stage[k+1])
        );
        // Publish each prefix as a scan element.
        always_comb scan_vec[k*W +: W] = stage[k+1];
    end

    // The last prefix is the fold.
    always_comb fold_val = stage[N];
endmodule

// File: rtl/sf_seq_loop.sv
// Module: sf_seq_loop
// Looped form: one operator cell, a state register and an operand counter.
// start seeds the state, and each accepted operand advances it. The N-th
// accepted operand ends the run and captures the fold.
// Assumes op_sel stays fixed during a run.
module sf_seq_loop #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] init_val,
    input  logic         start,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] state_q,
    output logic         scan_valid_q,
    output logic [W-1:0] fold_q,
    output logic         fold_valid_q
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          take;
    logic [W-1:0]  next_state;

    sf_op_cell #(.W(W)) i_body (
        .op_sel (op_sel),
        .lhs    (state_q),
        .rhs    (in_data),
        .res    (next_state)
    );

    // An operand counts only inside a run and never in a start cycle.
    always_comb take = run_q && in_valid && !start;

    // Update the state, the counter, the run flag and the fold capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            fold_q       <= '0;
            cnt_q        <= '0;
            run_q        <= 1'b0;
            scan_valid_q <= 1'b0;
            fold_valid_q <= 1'b0;
        end else begin
            scan_valid_q <= 1'b0;
            fold_valid_q <= 1'b0;
            if (start) begin
                state_q <= init_val;
                cnt_q   <= '0;
                run_q   <= 1'b1;
            end else if (take) begin
                state_q      <= next_state;
                scan_valid_q <= 1'b1;
                cnt_q        <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q        <= 1'b0;
                    fold_q       <= next_state;
                    fold_valid_q <= 1'b1;
                end
            end
        end
    end

    // R5: the state holds when nothing is offered.
    assert_state_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> $stable(state_q));

    // R6: the fold flag is a single-cycle pulse.
    assert_fold_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fold_valid_q |=> !fold_valid_q);

    // R6: a fold never comes without its last scan element.
    assert_fold_with_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fold_valid_q |-> scan_valid_q);

    // R4: a scan element only follows an offered operand.
    assert_scan_after_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid_q |-> $past(in_valid));

    // R7: a run never takes more than N operands.
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(N));

    // R3: the operator stays fixed while a run is active.
    assert_opsel_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start) |-> $stable(op_sel));
endmodule

// File: rtl/scan_fold_unit.sv
// Module: scan_fold_unit (top)
// Puts the unrolled and looped forms of the same loop body side by side.
// Both forms share op_sel and init_val. The unrolled form reads vec_in, and
// the looped form reads in_data one element per accepted cycle.
// Assumes W >= 1 and N >= 1.
module scan_fold_unit #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     op_sel,
    input  logic [W-1:0]   init_val,
    input  logic           start,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic [W-1:0]   scan_out,
    output logic           scan_valid,
    output logic [W-1:0]   fold_out,
    output logic           fold_valid,
    input  logic [N*W-1:0] vec_in,
    output logic [N*W-1:0] comb_scan,
    output logic [W-1:0]   comb_fold
);
    sf_comb_chain #(.W(W), .N(N)) i_chain (
        .op_sel   (op_sel),
        .init_val (init_val),
        .vec_in   (vec_in),
        .scan_vec (comb_scan),
        .fold_val (comb_fold)
    );

    sf_seq_loop #(.W(W), .N(N)) i_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_sel       (op_sel),
        .init_val     (init_val),
        .start        (start),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .state_q      (scan_out),
        .scan_valid_q (scan_valid),
        .fold_q       (fold_out),
        .fold_valid_q (fold_valid)
    );
endmodule

// File: tb/test_scan_fold_unit.sv
module test_scan_fold_unit;
    localparam int W = 16;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [1:0]     op_sel;
    logic [W-1:0]   init_val;
    logic           start;
    logic           in_valid;
    logic [W-1:0]   in_data;
    logic [W-1:0]   scan_out;
    logic           scan_valid;
    logic [W-1:0]   fold_out;
    logic           fold_valid;
    logic [N*W-1:0] vec_in;
    logic [N*W-1:0] comb_scan;
    logic [W-1:0]   comb_fold;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_fold_unit #(.W(W), .N(N)) i_scan_fold_unit (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .init_val(init_val),
        .start(start), .in_valid(in_valid), .in_data(in_data),
        .scan_out(scan_out), .scan_valid(scan_valid), .fold_out(fold_out),
        .fold_valid(fold_valid), .vec_in(vec_in), .comb_scan(comb_scan),
        .comb_fold(comb_fold)
    );

    // Reference operator, written from the encoding in R2.
    function automatic logic [W-1:0] ref_op(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            2'd0: return W'(a + b);
            2'd1: return W'(a * b);
            2'd2: return (a > b) ? a : b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One looped run checked against bench values and the unrolled outputs.
    task automatic run(logic [1:0] op, logic [W-1:0] init, logic [N*W-1:0] vec,
                       bit gaps, bit clash);
        logic [W-1:0] exp;
        logic [W-1:0] prev_fold;
        prev_fold = fold_out;
        op_sel = op; init_val = init; vec_in = vec;
        start = 1'b1; in_valid = clash; in_data = 16'hBEEF;
        tick();
        start = 1'b0; in_valid = 1'b0;
        check(clash ? "R8" : "R3", "state after start", scan_out, init);
        check("R6", "fold_out held into next run", fold_out, prev_fold);
        exp = init;
        for (int k = 0; k < N; k++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                tick();
                check("R5", "scan_valid during gap", {15'd0, scan_valid}, 16'd0);
                check("R5", "state during gap", scan_out, exp);
            end
            in_valid = 1'b1; in_data = vec[k*W +: W];
            tick();
            in_valid = 1'b0;
            exp = ref_op(op, exp, vec[k*W +: W]);
            check("R4", "scan_out", scan_out, exp);
            check("R4", "scan_valid", {15'd0, scan_valid}, 16'd1);
            check("R9", "comb_scan element", comb_scan[k*W +: W], exp);
            check("R10", "looped equals unrolled", scan_out, comb_scan[k*W +: W]);
            check("R6", "fold_valid timing", {15'd0, fold_valid}, (k == N-1) ? 16'd1 : 16'd0);
        end
        check("R6", "fold_out", fold_out, exp);
        check("R10", "fold equals comb_fold", fold_out, comb_fold);
        check("R9", "comb_fold", comb_fold, exp);
        tick();
        check("R6", "fold_valid one cycle", {15'd0, fold_valid}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [N*W-1:0] v;
        logic [W-1:0] held;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
        op_sel = 2'd0; init_val = '0; vec_in = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", "scan_valid", {15'd0, scan_valid}, 16'd0);
        check("R1", "fold_valid", {15'd0, fold_valid}, 16'd0);
        check("R1", "scan_out", scan_out, 16'd0);
        check("R1", "fold_out", fold_out, 16'd0);

        // R7: an operand before any start is ignored.
        in_valid = 1'b1; in_data = 16'd5;
        tick();
        in_valid = 1'b0;
        check("R7", "scan_valid before start", {15'd0, scan_valid}, 16'd0);
        check("R7", "scan_out before start", scan_out, 16'd0);

        // R2: multiply truncation, since 0x1000 * 0x0010 wraps to zero.
        for (int k = 0; k < N; k++) v[k*W +: W] = 16'h0010;
        run(2'd1, 16'h1000, v, 1'b0, 1'b0);
        check("R2", "multiply truncation", fold_out, 16'h0000);

        // R2: addition wraps.
        for (int k = 0; k < N; k++) v[k*W +: W] = 16'hF000;
        run(2'd0, 16'h1234, v, 1'b0, 1'b0);
        check("R2", "add wrap", fold_out, W'(16'h1234 + 8 * 16'hF000));

        // R2: unsigned max keeps a large seed.
        for (int k = 0; k < N; k++) v[k*W +: W] = W'(k * 16'h1111);
        run(2'd2, 16'h9000, v, 1'b0, 1'b0);
        check("R2", "unsigned max", fold_out, 16'h9000);

        // R7: an operand after the fold is ignored.
        held = scan_out;
        in_valid = 1'b1; in_data = 16'h7777;
        tick();
        in_valid = 1'b0;
        check("R7", "scan_valid after fold", {15'd0, scan_valid}, 16'd0);
        check("R7", "scan_out after fold", scan_out, held);
        check("R7", "fold_out after fold", fold_out, 16'h9000);

        // R8: start and an operand in the same cycle.
        for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
        run(2'd3, 16'h00A5, v, 1'b1, 1'b1);

        // Random runs with idle gaps.
        for (int r = 0; r < 24; r++) begin
            for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
            run(2'($urandom_range(0, 3)), W'($urandom), v, 1'b1, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule